// File: doc/BRIEF.md
# Parallel Video Frame Timing Generator

This block drives the parallel output side of a rolling-readout image pipeline. From a pixel clock it produces a frame strobe, a line strobe and a data bus. Each frame is a raster of lines of one fixed total length. A programmable number of lines carry a line strobe over a programmable number of columns. Guard intervals of fixed length separate the edges of the frame strobe from the first and last line strobes.

Optionally, two metadata lines can be placed before the image lines, two summary lines after them, or both. The metadata lines carry the column index and the summary lines carry its bitwise inverse. These are placeholder content for the logic that later fills them. Image lines pass the incoming pixel sample straight through. Every output changes on the falling clock edge, so a receiver can capture on the rising edge.

The configuration inputs are copied into a shadow set only at a frame boundary, so a frame never mixes two settings. The user must set the line length to at least the column count plus 12, and the frame length to at least one more than the number of strobed lines.

Top module: `vtg_frame_timer`

## Requirements
- R1: While rst_n is low, fv, lv and dout are all 0.
- R2: fv rises exactly 6 pixel clocks before the first lv rise of its frame.
- R3: fv falls exactly 6 pixel clocks after the last lv of its frame falls.
- R4: Every lv pulse lasts cfg_cols clocks. Successive lv rises within a frame are cfg_line_len clocks apart, and successive fv rises are cfg_line_len*cfg_frame_len clocks apart.
- R5: A frame holds cfg_rows lv pulses, plus 2 when cfg_emb_en is 1, plus 2 when cfg_stat_en is 1.
- R6: With cfg_emb_en=1, the first two lv pulses of a frame carry the zero-based column index (0,1,2,...) on dout.
- R7: During image lines, dout equals the pix_in value present at the falling edge that launches it.
- R8: With cfg_stat_en=1, the last two lv pulses of a frame carry the bitwise inverse of the zero-based column index.
- R9: dout is 0 whenever lv is 0, and lv is never 1 while fv is 0.
- R10: fv, lv and dout change only on the falling edge of pclk and are stable across the rising edge.
- R11: A configuration change made during a frame does not affect that frame and applies from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock; outputs launch on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cols | input | 12 | Strobed columns per line |
| cfg_rows | input | 12 | Image lines per frame |
| cfg_line_len | input | 12 | Total line length in clocks |
| cfg_frame_len | input | 12 | Total frame length in lines |
| cfg_emb_en | input | 1 | Add two metadata lines before the image |
| cfg_stat_en | input | 1 | Add two summary lines after the image |
| pix_in | input | 12 | Incoming pixel sample |
| fv | output | 1 | Frame strobe |
| lv | output | 1 | Line strobe |
| dout | output | 12 | Output data bus |

## Verification
A wrong column or line counter shows up within one line. The lv pulse width drifts, or the spacing between rises stops equal to the line length. A corrupted row classification puts index or inverse patterns on the wrong lines, or changes the lv pulse count, and this is visible before the frame ends. A shadow register loaded at the wrong moment makes the frame in progress take on new widths as soon as the next line begins. An off-by-one in the guard comparisons moves the fv edges relative to lv at the first or last line of every frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int CW = 12;
    localparam int RW = 12;

    typedef struct packed {
        logic [CW-1:0] cols;
        logic [RW-1:0] rows;
        logic [CW-1:0] line_len;
        logic [RW-1:0] frame_len;
        logic          emb_en;
        logic          stat_en;
    } vtg_cfg_t;

    typedef enum logic [1:0] {
        ROW_BLANK = 2'd0,
        ROW_EMB   = 2'd1,
        ROW_ACT   = 2'd2,
        ROW_STAT  = 2'd3
    } row_kind_e;
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow
    import vtg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  vtg_cfg_t cfg_in,
    output vtg_cfg_t cfg_q
);
    vtg_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (load) cfg_d = cfg_in;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/vtg_scan.sv
module vtg_scan
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] line_len,
    input  logic [RW-1:0] frame_len,
    output logic [CW-1:0] h,
    output logic [RW-1:0] v,
    output logic          wrap
);
    typedef struct packed {
        logic [CW-1:0] h;
        logic [RW-1:0] v;
    } scan_t;

    scan_t s_d, s_q;
    logic  line_end, frame_end;

    always_comb begin
        line_end  = (s_q.h == line_len - CW'(1));
        frame_end = (s_q.v == frame_len - RW'(1));
        wrap      = run && line_end && frame_end;
        s_d       = s_q;
        if (!run) begin
            s_d = '0;
        end else if (line_end) begin
            s_d.h = '0;
            s_d.v = frame_end ? '0 : s_q.v + RW'(1);
        end else begin
            s_d.h = s_q.h + CW'(1);
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign h = s_q.h;
    assign v = s_q.v;
endmodule

// File: rtl/vtg_row_map.sv
module vtg_row_map
    import vtg_pkg::*;
#(
    parameter int GUARD     = 6,
    parameter int META_ROWS = 2
) (
    input  logic [CW-1:0] h,
    input  logic [RW-1:0] v,
    input  vtg_cfg_t      cfg,
    output logic          fv,
    output logic          lv,
    output row_kind_e     kind,
    output logic [CW-1:0] col
);
    localparam int HX = CW + 1;
    localparam int VX = RW + 2;

    logic [VX-1:0] emb_rows, stat_rows, img_end, out_rows, v_x;
    logic [HX-1:0] h_x, lv_lo, lv_hi, fv_hi;

    always_comb begin
        emb_rows  = cfg.emb_en  ? VX'(META_ROWS) : '0;
        stat_rows = cfg.stat_en ? VX'(META_ROWS) : '0;
        img_end   = emb_rows + VX'(cfg.rows);
        out_rows  = img_end + stat_rows;
        v_x       = VX'(v);
        h_x       = HX'(h);
        lv_lo     = HX'(GUARD);
        lv_hi     = lv_lo + HX'(cfg.cols);
        fv_hi     = lv_hi + HX'(GUARD);

        lv = (v_x < out_rows) && (h_x >= lv_lo) && (h_x < lv_hi);
        fv = (v_x + VX'(1) < out_rows) ||
             ((v_x + VX'(1) == out_rows) && (h_x < fv_hi));

        if (v_x < emb_rows)      kind = ROW_EMB;
        else if (v_x < img_end)  kind = ROW_ACT;
        else if (v_x < out_rows) kind = ROW_STAT;
        else                     kind = ROW_BLANK;

        col = h - CW'(GUARD);
    end
endmodule

// File: rtl/vtg_frame_timer.sv
module vtg_frame_timer
    import vtg_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int GUARD     = 6,
    parameter int META_ROWS = 2
) (
    input  logic              pclk,
    input  logic              rst_n,
    input  logic [CW-1:0]     cfg_cols,
    input  logic [RW-1:0]     cfg_rows,
    input  logic [CW-1:0]     cfg_line_len,
    input  logic [RW-1:0]     cfg_frame_len,
    input  logic              cfg_emb_en,
    input  logic              cfg_stat_en,
    input  logic [DATA_W-1:0] pix_in,
    output logic              fv,
    output logic              lv,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic              run;
        logic              fv;
        logic              lv;
        logic [DATA_W-1:0] dout;
    } out_t;

    out_t          o_d, o_q;
    vtg_cfg_t      cfg_live, cfg_sh;
    logic          load, wrap, map_fv, map_lv;
    logic [CW-1:0] h, col;
    logic [RW-1:0] v;
    row_kind_e     kind;

    always_comb begin
        cfg_live.cols      = cfg_cols;
        cfg_live.rows      = cfg_rows;
        cfg_live.line_len  = cfg_line_len;
        cfg_live.frame_len = cfg_frame_len;
        cfg_live.emb_en    = cfg_emb_en;
        cfg_live.stat_en   = cfg_stat_en;
    end

    assign load = !o_q.run || wrap;

    vtg_shadow u_shadow (
        .clk    (pclk),
        .rst_n  (rst_n),
        .load   (load),
        .cfg_in (cfg_live),
        .cfg_q  (cfg_sh)
    );

    vtg_scan u_scan (
        .clk       (pclk),
        .rst_n     (rst_n),
        .run       (o_q.run),
        .line_len  (cfg_sh.line_len),
        .frame_len (cfg_sh.frame_len),
        .h         (h),
        .v         (v),
        .wrap      (wrap)
    );

    vtg_row_map #(.GUARD(GUARD), .META_ROWS(META_ROWS)) u_map (
        .h    (h),
        .v    (v),
        .cfg  (cfg_sh),
        .fv   (map_fv),
        .lv   (map_lv),
        .kind (kind),
        .col  (col)
    );

    always_comb begin
        o_d.run  = 1'b1;
        o_d.fv   = o_q.run && map_fv;
        o_d.lv   = o_q.run && map_lv;
        o_d.dout = '0;
        if (o_d.lv) begin
            case (kind)
                ROW_EMB:  o_d.dout = DATA_W'(col);
                ROW_ACT:  o_d.dout = pix_in;
                ROW_STAT: o_d.dout = ~DATA_W'(col);
                default:  o_d.dout = '0;
            endcase
        end
    end

    always_ff @(negedge pclk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign fv   = o_q.fv;
    assign lv   = o_q.lv;
    assign dout = o_q.dout;
endmodule

// File: rtl/vtg_frame_timer_chk.sv
module vtg_frame_timer_chk #(
    parameter int DATA_W = 12,
    parameter int GUARD  = 6
) (
    input logic              pclk,
    input logic              rst_n,
    input logic              fv,
    input logic              lv,
    input logic [DATA_W-1:0] dout
);
    localparam int        NW   = 16;
    localparam logic [NW-1:0] SAT = '1;

    logic          fv_p, lv_p, first_pend, w_ref_ok;
    logic [NW-1:0] lead_cnt, lag_cnt, w_cnt, w_ref;

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            fv_p <= 1'b0; lv_p <= 1'b0; first_pend <= 1'b0; w_ref_ok <= 1'b0;
            lead_cnt <= '0; lag_cnt <= '0; w_cnt <= '0; w_ref <= '0;
        end else begin
            fv_p <= fv;
            lv_p <= lv;
            if (fv && !fv_p)             lead_cnt <= NW'(1);
            else if (lead_cnt != SAT)    lead_cnt <= lead_cnt + NW'(1);
            if (!lv && lv_p)             lag_cnt <= NW'(1);
            else if (lag_cnt != SAT)     lag_cnt <= lag_cnt + NW'(1);
            if (fv && !fv_p)             first_pend <= 1'b1;
            else if (lv && !lv_p)        first_pend <= 1'b0;
            if (lv)                      w_cnt <= lv_p ? w_cnt + NW'(1) : NW'(1);
            if (fv && !fv_p)             w_ref_ok <= 1'b0;
            else if (!lv && lv_p && !w_ref_ok) begin
                w_ref_ok <= 1'b1;
                w_ref    <= w_cnt;
            end
        end
    end

    // R2
    fv_lead_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        (lv && !lv_p && first_pend) |-> (lead_cnt == NW'(GUARD)));

    // R3
    fv_lag_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        (!fv && fv_p) |-> (lag_cnt == NW'(GUARD)));

    // R4
    lv_width_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        (!lv && lv_p && w_ref_ok) |-> (w_cnt == w_ref));

    // R9
    lv_in_fv_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        lv |-> fv);

    // R9
    idle_zero_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        !lv |-> (dout == '0));
endmodule

bind vtg_frame_timer vtg_frame_timer_chk #(.DATA_W(DATA_W), .GUARD(GUARD)) u_chk (
    .pclk  (pclk),
    .rst_n (rst_n),
    .fv    (fv),
    .lv    (lv),
    .dout  (dout)
);

// File: tb/tb_vtg_frame_timer.sv
module tb_vtg_frame_timer;
    logic        pclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_cols = 12'd8, cfg_rows = 12'd4, cfg_line_len = 12'd20, cfg_frame_len = 12'd6;
    logic        cfg_emb_en = 1'b0, cfg_stat_en = 1'b0;
    logic [11:0] pix_in = '0;
    logic        fv, lv;
    logic [11:0] dout;

    int n_chk = 0, n_fail = 0;
    logic        s_fv, s_lv;
    logic [11:0] s_d, exp_pix, drv_pix = '0;
    int m_v[6];

    // columns, rows, line length, frame length, embedded, statistics
    localparam int VEC[5][6] = '{
        '{8, 4, 20, 6, 0, 0},
        '{8, 3, 24, 8, 1, 0},
        '{5, 2, 30, 7, 0, 1},
        '{6, 3, 18, 8, 1, 1},
        '{16, 5, 40, 12, 1, 1}
    };

    vtg_frame_timer dut (
        .pclk(pclk), .rst_n(rst_n), .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
        .cfg_line_len(cfg_line_len), .cfg_frame_len(cfg_frame_len),
        .cfg_emb_en(cfg_emb_en), .cfg_stat_en(cfg_stat_en), .pix_in(pix_in),
        .fv(fv), .lv(lv), .dout(dout)
    );

    always #5 pclk = ~pclk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int c[6]);
        cfg_cols = 12'(c[0]); cfg_rows = 12'(c[1]); cfg_line_len = 12'(c[2]);
        cfg_frame_len = 12'(c[3]); cfg_emb_en = c[4] != 0; cfg_stat_en = c[5] != 0;
    endtask

    task automatic step();
        @(posedge pclk); #1;
        s_fv = fv; s_lv = lv; s_d = dout;
        exp_pix = drv_pix;
        drv_pix = drv_pix + 12'd1;
        pix_in  = drv_pix;
    endtask

    task automatic measure(input int c[6], input bit do_mid);
        int cols = c[0], line = c[2], frame = c[3], emb = c[4], stat = c[5];
        int outr = c[1] + 2 * emb + 2 * stat;
        int t = 0, lines = 0, lead = -1, lag = -1, last_rise = 0, fall_t = 0, col = 0;
        int bad_w = 0, bad_p = 0, e_emb = 0, e_act = 0, e_stat = 0, e_idle = 0;
        logic pfv, plv;
        logic [11:0] ex;
        do step(); while (s_fv);
        do step(); while (!s_fv);
        pfv = 1'b1; plv = 1'b0;
        forever begin
            step(); t++;
            if (s_fv && !pfv) break;
            if (s_lv && !plv) begin
                lines++;
                if (lines == 1) lead = t;
                else if (t - last_rise != line) bad_p++;
                last_rise = t; col = 0;
                if (do_mid && lines == 2) set_cfg(m_v);
            end
            if (s_lv) begin
                int r = lines - 1;
                if (emb != 0 && r < 2) begin
                    ex = 12'(col); if (s_d != ex) e_emb++;
                end else if (stat != 0 && r >= 2 * emb + c[1]) begin
                    ex = ~12'(col); if (s_d != ex) e_stat++;
                end else if (s_d != exp_pix) e_act++;
                col++;
            end
            if (!s_lv && plv) begin
                if (col != cols) bad_w++;
                fall_t = t;
            end
            if ((!s_lv && s_d != 0) || (s_lv && !s_fv)) e_idle++;
            if (!s_fv && pfv) lag = t - fall_t;
            pfv = s_fv; plv = s_lv;
        end
        chk(lead == 6, "R2", "fv-to-lv lead", lead, 6);
        chk(lag == 6, "R3", "lv-to-fv lag", lag, 6);
        chk(bad_w == 0, "R4", "lv widths off", bad_w, 0);
        chk(bad_p == 0, "R4", "line periods off", bad_p, 0);
        chk(t == line * frame, "R4", "frame period", t, line * frame);
        chk(lines == outr, "R5", "lv pulses", lines, outr);
        chk(e_emb == 0, "R6", "metadata mismatches", e_emb, 0);
        chk(e_act == 0, "R7", "image mismatches", e_act, 0);
        chk(e_stat == 0, "R8", "summary mismatches", e_stat, 0);
        chk(e_idle == 0, "R9", "idle violations", e_idle, 0);
    endtask

    initial begin
        #2000000;
        chk(1'b0, "WATCHDOG", "timeout", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cv[6];
        repeat (4) @(posedge pclk);
        #1;
        // R1 reset state
        chk(fv == 0 && lv == 0 && dout == 0, "R1", "outputs in reset", {fv, lv}, 0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < 5; i++) begin
            for (int k = 0; k < 6; k++) cv[k] = VEC[i][k];
            set_cfg(cv);
            measure(cv, 1'b0);
        end

        // R11 mid-frame change: current frame keeps the old settings
        for (int k = 0; k < 6; k++) cv[k] = VEC[0][k];
        for (int k = 0; k < 6; k++) m_v[k] = VEC[4][k];
        set_cfg(cv);
        measure(cv, 1'b0);
        $display("R11 mid-frame change, frame in progress");
        measure(cv, 1'b1);
        $display("R11 following frame");
        measure(m_v, 1'b0);

        // R10 outputs stable across the rising edge
        begin
            int bad = 0;
            logic [13:0] a;
            for (int n = 0; n < 200; n++) begin
                @(negedge pclk); #4;
                a = {fv, lv, dout};
                @(posedge pclk); #1;
                if ({fv, lv, dout} != a) bad++;
            end
            chk(bad == 0, "R10", "changes at rising edge", bad, 0);
        end

        // R1 asynchronous reset during a frame
        do step(); while (!s_lv);
        #2 rst_n = 1'b0;
        #1;
        chk(fv == 0 && lv == 0 && dout == 0, "R1", "outputs after mid-frame reset", {fv, lv}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule